// File: doc/BRIEF.md
# Dual Direction-Masked Peripheral Port Registers

This block gives a host two identical 7-pin peripheral ports. Each port has a direction register and a data register. Each pin whose direction bit is set is an output, and the pin output bus drives the data bit ANDed with that direction bit. A read of the data register mixes two sources. Pins configured as inputs show the live pin input. Pins configured as outputs show the value being driven. A further register exists for each port that has no pin. This eighth data bit is kept purely for readback and always returns the value it was last written with. A shared pair of control registers holds one port-select bit and one latch-enable bit per port. Both registers come straight out as plain outputs.

The host side is a simple register bus with independent write and read strobes, so a write and a read may land in the same cycle. Every register sits at an odd byte address. Even addresses are dead: writes to them are dropped and reads return zero. Read data is registered and returns with a valid flag one cycle after the read strobe. There is no back-pressure: the bus never stalls, and each read strobe produces exactly one valid beat in the following cycle.

Top module: `dmp_port_pair`

## Requirements
- R1: After reset, both direction registers, both data latches, the pin outputs, the port-select bits and the latch-enable bits are all zero. A data read with every pin input at 1 therefore returns 0x7F.
- R2: A direction write stores only bits 6..0. Bit 7 of the written byte has no effect on pin output or on readback masking.
- R3: A data write sets the port's 7 pin outputs, in the next cycle, to written bits 6..0 ANDed with the port's direction bits. A pin whose direction bit is 0 is never driven high.
- R4: Bit 7 of a data read always equals bit 7 of the last data write to that port, whatever the direction setting. It is 0 after reset.
- R5: A read strobe yields rd_valid=1 in the next cycle. rd_data then holds, for a data address, {latched bit 7, (pin input AND NOT direction) OR driven pins}, taken from the state and pin inputs at the strobe edge. Without a strobe, rd_valid and rd_data are 0.
- R6: A direction write changes the pin outputs in the next cycle to the current data latch ANDed with the new direction.
- R7: Writing 0x09 sets port_sel and writing 0x0B sets latch_en. In both, written bit 0 maps to port 1 and bit 1 to port 2. Other bits are ignored.
- R8: Writes to even addresses or to unmapped odd addresses change nothing. Reads of any address other than a data address return 0x00.
- R9: The address map is 0x01 = port 1 data, 0x03 = port 2 data, 0x05 = port 1 direction, 0x07 = port 2 direction. A write to one port never changes the other port's pins or readback.
- R10: When a write and a read fall in the same cycle, the read returns the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 7 | Read byte address |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| pin_in | input | 14 | Pin inputs; port 1 in bits 6..0, port 2 in bits 13..7 |
| pin_out | output | 14 | Pin outputs, same packing |
| port_sel | output | 2 | Port-select bits, bit 0 = port 1 |
| latch_en | output | 2 | Latch-enable bits, bit 0 = port 1 |

## Verification
Several functions can coincide in one cycle. The main case is a direction or data write landing together with a read of the same port. A second case is a pin-input change landing together with a read. The bench provokes the first case directly: it flips a port's direction from all-input to all-output while reading that port's data. The read must still show the live pins under the old mask, and only the next read shows the driven value. A long stretch of random write and read traffic, issued together with changing pin inputs, is compared every cycle against a behavioural model. The model computes the read from the pre-write state before it applies the write.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  localparam int DMP_DATA_W = 8;
  localparam int DMP_ADDR_W = 7;
  localparam int DMP_NUM_PORTS = 2;

  // odd byte address of register slot idx in a bank starting at base
  function automatic int slot_addr(input int base, input int idx);
    return base + 2 * idx;
  endfunction
endpackage

// File: rtl/dmp_addr_decode.sv
module dmp_addr_decode #(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W = 7
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [NUM_PORTS-1:0] data_we,
  output logic [NUM_PORTS-1:0] dir_we,
  output logic                 sel_we,
  output logic                 lat_we,
  output logic [NUM_PORTS-1:0] rd_hit
);
  import dmp_pkg::*;

  localparam int DATA_BASE = 1;
  localparam int DIR_BASE  = DATA_BASE + 2 * NUM_PORTS;
  localparam int SEL_ADDR  = DIR_BASE + 2 * NUM_PORTS;
  localparam int LAT_ADDR  = SEL_ADDR + 2;

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    assign data_we[k] = wr_en && (wr_addr == ADDR_W'(slot_addr(DATA_BASE, k)));
    assign dir_we[k]  = wr_en && (wr_addr == ADDR_W'(slot_addr(DIR_BASE, k)));
    assign rd_hit[k]  = (rd_addr == ADDR_W'(slot_addr(DATA_BASE, k)));
  end

  assign sel_we = wr_en && (wr_addr == ADDR_W'(SEL_ADDR));
  assign lat_we = wr_en && (wr_addr == ADDR_W'(LAT_ADDR));
endmodule

// File: rtl/dmp_port_lane.sv
module dmp_port_lane #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic              dir_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-2:0] pin_in,
  output logic [DATA_W-2:0] pin_out,
  output logic [DATA_W-1:0] rd_value
);
  localparam int PIN_W = DATA_W - 1;

  logic [PIN_W-1:0] dir_q, data_q, pin_q;
  logic             top_q;
  logic [PIN_W-1:0] dir_nxt, data_nxt;

  always_comb begin
    dir_nxt  = dir_we  ? wdata[PIN_W-1:0] : dir_q;
    data_nxt = data_we ? wdata[PIN_W-1:0] : data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
      pin_q  <= '0;
      top_q  <= 1'b0;
    end else begin
      dir_q  <= dir_nxt;
      data_q <= data_nxt;
      pin_q  <= data_nxt & dir_nxt;
      if (data_we) top_q <= wdata[DATA_W-1];
    end
  end

  assign pin_out  = pin_q;
  assign rd_value = {top_q, (pin_in & ~dir_q) | pin_q};

  assert_pins_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q & ~dir_q) == '0);
  assert_bit7_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(top_q));
  assert_dir_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && !data_we) |=> pin_q == ($past(data_q) & $past(wdata[PIN_W-1:0])));
endmodule

// File: rtl/dmp_ctrl_reg.sv
module dmp_ctrl_reg #(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_we,
  input  logic                 lat_we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_PORTS-1:0] port_sel,
  output logic [NUM_PORTS-1:0] latch_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_sel <= '0;
      latch_en <= '0;
    end else begin
      if (sel_we) port_sel <= wdata[NUM_PORTS-1:0];
      if (lat_we) latch_en <= wdata[NUM_PORTS-1:0];
    end
  end

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(port_sel));
  assert_lat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_we |=> $stable(latch_en));
endmodule

// File: rtl/dmp_port_pair.sv
module dmp_port_pair #(
  parameter int NUM_PORTS = dmp_pkg::DMP_NUM_PORTS,
  parameter int DATA_W    = dmp_pkg::DMP_DATA_W,
  parameter int ADDR_W    = dmp_pkg::DMP_ADDR_W,
  localparam int PIN_W    = DATA_W - 1,
  localparam int BUS_W    = NUM_PORTS * PIN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  input  logic [BUS_W-1:0]     pin_in,
  output logic [BUS_W-1:0]     pin_out,
  output logic [NUM_PORTS-1:0] port_sel,
  output logic [NUM_PORTS-1:0] latch_en
);
  logic [NUM_PORTS-1:0] data_we, dir_we, rd_hit;
  logic                 sel_we, lat_we;
  logic [DATA_W-1:0]    lane_rd [NUM_PORTS];
  logic [DATA_W-1:0]    rd_mux;

  dmp_addr_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .data_we(data_we), .dir_we(dir_we), .sel_we(sel_we), .lat_we(lat_we),
    .rd_hit(rd_hit)
  );

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_lane
    dmp_port_lane #(.DATA_W(DATA_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .data_we(data_we[k]), .dir_we(dir_we[k]), .wdata(wr_data),
      .pin_in(pin_in[k*PIN_W +: PIN_W]),
      .pin_out(pin_out[k*PIN_W +: PIN_W]),
      .rd_value(lane_rd[k])
    );
  end

  dmp_ctrl_reg #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .lat_we(lat_we),
    .wdata(wr_data), .port_sel(port_sel), .latch_en(latch_en)
  );

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_PORTS; k++)
      if (rd_hit[k]) rd_mux = rd_mux | lane_rd[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_en ? rd_mux : '0;
      rd_valid <= rd_en;
    end
  end

  assert_even_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[0]) |=> ($stable(pin_out) && $stable(port_sel) && $stable(latch_en)));
  assert_even_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_addr[0]) |=> rd_data == '0);
  assert_rvalid_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rvalid_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && rd_data == '0));
endmodule

// File: tb/dmp_port_pair_tb.sv
module dmp_port_pair_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [13:0] pin_in = '1;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [13:0] pin_out;
  logic [1:0]  port_sel, latch_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmp_port_pair u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .pin_in(pin_in), .pin_out(pin_out), .port_sel(port_sel), .latch_en(latch_en)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "R1";

  logic [6:0] m_dir [2], m_dat [2], m_pin [2];
  logic       m_b7 [2];
  logic [1:0] m_sel, m_lat;
  logic [7:0] m_rd;
  logic       m_rv;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_dir[k] = '0; m_dat[k] = '0; m_pin[k] = '0; m_b7[k] = 1'b0;
    end
    m_sel = '0; m_lat = '0; m_rd = '0; m_rv = 1'b0;
  endtask

  // read first from pre-write state (R10), then apply the write
  task automatic model_edge();
    m_rv = rd_en;
    m_rd = 8'h00;
    if (rd_en && (rd_addr == 7'h01 || rd_addr == 7'h03)) begin
      int p = (rd_addr == 7'h01) ? 0 : 1;
      logic [6:0] pins = pin_in[p*7 +: 7];
      m_rd = {m_b7[p], (pins & ~m_dir[p]) | m_pin[p]};
    end
    if (wr_en) begin
      case (wr_addr)
        7'h01, 7'h03: begin
          int p = (wr_addr == 7'h01) ? 0 : 1;
          m_dat[p] = wr_data[6:0];
          m_b7[p]  = wr_data[7];
          m_pin[p] = m_dat[p] & m_dir[p];
        end
        7'h05, 7'h07: begin
          int p = (wr_addr == 7'h05) ? 0 : 1;
          m_dir[p] = wr_data[6:0];
          m_pin[p] = m_dat[p] & m_dir[p];
        end
        7'h09: m_sel = wr_data[1:0];
        7'h0B: m_lat = wr_data[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({cur_tag, " pin_out"}, 32'(pin_out), 32'({m_pin[1], m_pin[0]}));
    chk({cur_tag, " port_sel"}, 32'(port_sel), 32'(m_sel));
    chk({cur_tag, " latch_en"}, 32'(latch_en), 32'(m_lat));
    chk({cur_tag, " rd_valid"}, 32'(rd_valid), 32'(m_rv));
    chk({cur_tag, " rd_data"}, 32'(rd_data), 32'(m_rd));
  endtask

  task automatic op(input logic w, input logic [6:0] wa, input logic [7:0] wd,
                    input logic r, input logic [6:0] ra);
    wr_en = w; wr_addr = wa; wr_data = wd; rd_en = r; rd_addr = ra;
    step();
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, undriven pins read high
    cur_tag = "R1";
    pin_in = '1;
    op(0, 0, 0, 1, 7'h01);
    chk("R1 reset read port1", 32'(rd_data), 32'h7F);
    op(0, 0, 0, 1, 7'h03);
    chk("R1 reset read port2", 32'(rd_data), 32'h7F);

    // R2 / R3: direction bit 7 dropped, pins = data & dir
    cur_tag = "R3";
    op(1, 7'h05, 8'hFF, 0, 0);
    op(1, 7'h01, 8'hA5, 0, 0);
    chk("R3 pins after data write", 32'(pin_out[6:0]), 32'h25);
    cur_tag = "R2";
    pin_in = '0;
    op(0, 0, 0, 1, 7'h01);
    chk("R2 read with full direction", 32'(rd_data), 32'hA5);

    // R4: bit 7 latched regardless of direction
    cur_tag = "R4";
    op(1, 7'h05, 8'h00, 0, 0);
    op(1, 7'h01, 8'h80, 0, 0);
    op(0, 0, 0, 1, 7'h01);
    chk("R4 bit7 readback set", 32'(rd_data), 32'h80);
    op(1, 7'h01, 8'h00, 1, 7'h01);
    op(0, 0, 0, 1, 7'h01);
    chk("R4 bit7 readback cleared", 32'(rd_data), 32'h00);

    // R6: direction change re-drives pins from data latch
    cur_tag = "R6";
    op(1, 7'h01, 8'h55, 0, 0);
    chk("R6 pins with input direction", 32'(pin_out[6:0]), 32'h00);
    op(1, 7'h05, 8'h0F, 0, 0);
    chk("R6 pins after direction write", 32'(pin_out[6:0]), 32'h05);

    // R7: control bit mapping
    cur_tag = "R7";
    op(1, 7'h09, 8'hFE, 0, 0);
    chk("R7 port_sel", 32'(port_sel), 32'h2);
    op(1, 7'h0B, 8'h01, 0, 0);
    chk("R7 latch_en", 32'(latch_en), 32'h1);

    // R8: even and unmapped addresses
    cur_tag = "R8";
    op(1, 7'h00, 8'hFF, 0, 0);
    op(1, 7'h02, 8'hFF, 0, 0);
    op(1, 7'h04, 8'hFF, 0, 0);
    op(1, 7'h0A, 8'hFF, 0, 0);
    op(1, 7'h0D, 8'hFF, 0, 0);
    chk("R8 pins untouched", 32'(pin_out), 32'h0005);
    chk("R8 sel untouched", 32'(port_sel), 32'h2);
    pin_in = '1;
    op(0, 0, 0, 1, 7'h02);
    chk("R8 even read zero", 32'(rd_data), 32'h00);
    op(0, 0, 0, 1, 7'h05);
    chk("R8 direction read zero", 32'(rd_data), 32'h00);

    // R9: port independence
    cur_tag = "R9";
    op(1, 7'h07, 8'h7F, 0, 0);
    op(1, 7'h03, 8'h3C, 0, 0);
    chk("R9 port2 pins", 32'(pin_out[13:7]), 32'h3C);
    chk("R9 port1 pins kept", 32'(pin_out[6:0]), 32'h05);

    // R10: write and read in one cycle
    cur_tag = "R10";
    op(1, 7'h05, 8'h00, 0, 0);
    pin_in[6:0] = 7'h2A;
    op(1, 7'h05, 8'h7F, 1, 7'h01);
    chk("R10 read sees old direction", 32'(rd_data), 32'h2A);
    op(0, 0, 0, 1, 7'h01);
    chk("R10 next read sees new direction", 32'(rd_data), 32'h55);

    // R5: random traffic against the model
    cur_tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      pin_in = 14'($urandom);
      op(1'($urandom), 7'($urandom_range(0, 15)), 8'($urandom),
         1'($urandom), 7'($urandom_range(0, 15)));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule